// File: doc/BRIEF.md
# Configurable Dual-Port RAM Pipeline

This block is a synchronous two-port memory whose ports A and B can both read and write the same storage array. Every port has an enable, an address, per-lane write enables, write data and read data. Each port has its own write collision mode, which sets what its read data shows during a write. Each port can also add output registers at two points: straight after the array, and after the final output select. Both ports run on one shared clock, so a write from each port to the same word in the same cycle has a defined result.

The register that drives a port's read data is its last output stage. When the port is configured for it, that stage has its own clock enable; otherwise the port enable drives it. The port's synchronous reset loads a per-port constant into that last stage only. When a port has no output registers, the reset loads the array read latch instead. Read latency is one cycle plus one cycle for each output register the port has enabled.

Top module: `dpram_cfg`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (ADDR_W >= 1, so at least 2 words). A word written through either port can be read back through either port.
- R2: With its enable held high, a port shows the word read at cycle t on its read data output after 1 + PRIM_REG_x + CORE_REG_x rising edges.
- R3: In write-first mode (MODE_x = WR_FIRST, code 0), a write returns the stored result as read data. For lanes without a write enable this is the old content; for the written lanes it is the new data.
- R4: In read-first mode (RD_FIRST, code 1), a write returns the word the address held before the write.
- R5: In no-change mode (NO_CHG, code 2), a write leaves the array read latch holding its previous value.
- R6: With USE_BYTE_WE = 1 the write enable has DATA_W/BYTE_W bits. Bit k writes data bits [k*BYTE_W +: BYTE_W] and leaves the other lanes unchanged. With USE_BYTE_WE = 0 the write enable is one bit wide and writes the whole word.
- R7: When both ports write the same address in the same cycle, port A's data is stored in each lane that port A enables. Port B's data is stored only in the lanes that port B alone enables.
- R8: While a port's enable is low, that port writes nothing, and its array read latch and its non-final output registers hold. Without a dedicated register enable, the port's read data output also holds.
- R9: When USE_RCE_x = 1 and the port has at least one output register, the last output stage loads only when regce_x is high, whatever the value of en_x.
- R10: A high rst_x at a rising edge loads RST_VAL_x into the port's last output stage, so read data equals RST_VAL_x after that edge. Earlier stages keep their contents. With no output registers, the array read latch is the stage that is loaded.
- R11: PRIM_REG_x (register after the array) and CORE_REG_x (register after the output select) are independent per-port parameters, and all four combinations work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_a | input | 1 | Port A synchronous reset of the last output stage |
| en_a | input | 1 | Port A enable for array access and pipeline |
| regce_a | input | 1 | Port A last-stage clock enable (used when USE_RCE_A = 1) |
| we_a | input | WE_W | Port A lane write enables |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A read data |
| rst_b | input | 1 | Port B synchronous reset of the last output stage |
| en_b | input | 1 | Port B enable for array access and pipeline |
| regce_b | input | 1 | Port B last-stage clock enable (used when USE_RCE_B = 1) |
| we_b | input | WE_W | Port B lane write enables |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B read data |

## Verification
The bench runs two instances that cover four port configurations: latencies of 1, 2 and 3, each write mode, and the dedicated register enable both present and absent. A cycle model predicts every port output. If the reset loaded the whole pipeline instead of only the last stage, the outputs in the cycles after reset would show the reset value where they should show older pipeline data. A design that let regce drive the inner stages would skip or repeat words. A design that got the write modes or the lane enables wrong would show the wrong word during writes, or corrupt neighbouring lanes. A design that gave port B priority in same-address writes would be caught when the word is read back.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        WR_FIRST = 2'd0,
        RD_FIRST = 2'd1,
        NO_CHG   = 2'd2
    } wmode_e;

    // Number of write-enable lanes for a given data width and lane size.
    function automatic int lane_count(input int data_w, input int byte_w, input bit use_lanes);
        return use_lanes ? (data_w / byte_w) : 1;
    endfunction

    // Width of one write-enable lane.
    function automatic int lane_width(input int data_w, input int byte_w, input bit use_lanes);
        return use_lanes ? byte_w : data_w;
    endfunction

endpackage

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              en_a,
    input  logic [LANES-1:0]  we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    input  logic              en_b,
    input  logic [LANES-1:0]  we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] old_a,
    output logic [DATA_W-1:0] new_a,
    output logic [DATA_W-1:0] old_b,
    output logic [DATA_W-1:0] new_b
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign old_a = mem[addr_a];
    assign old_b = mem[addr_b];

    // Word as it will look after this port's own write (lane merge).
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign new_a[k*LANE_W +: LANE_W] = (en_a && we_a[k]) ? din_a[k*LANE_W +: LANE_W]
                                                             : old_a[k*LANE_W +: LANE_W];
        assign new_b[k*LANE_W +: LANE_W] = (en_b && we_b[k]) ? din_b[k*LANE_W +: LANE_W]
                                                             : old_b[k*LANE_W +: LANE_W];
    end

    // Port B is applied first so that port A's lanes win on a shared address.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (en_b && we_b[k]) mem[addr_b][k*LANE_W +: LANE_W] <= din_b[k*LANE_W +: LANE_W];
        end
        for (int k = 0; k < LANES; k++) begin
            if (en_a && we_a[k]) mem[addr_a][k*LANE_W +: LANE_W] <= din_a[k*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
    import dpram_pkg::*;
#(
    parameter int          W        = 16,
    parameter wmode_e      MODE     = WR_FIRST,
    parameter bit          PRIM_REG = 1'b0,
    parameter bit          CORE_REG = 1'b0,
    parameter bit          USE_RCE  = 1'b0,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         regce,
    input  logic         wr,
    input  logic [W-1:0] old_w,
    input  logic [W-1:0] new_w,
    output logic [W-1:0] dout
);
    localparam bit HAS_REG = PRIM_REG || CORE_REG;

    logic         last_ce;
    logic [W-1:0] latch_q;
    logic [W-1:0] prim_out;
    logic [W-1:0] core_out;

    assign last_ce = (USE_RCE && HAS_REG) ? regce : en;

    // Array read latch: the last stage only when no register is configured.
    always_ff @(posedge clk) begin
        if (rst && !HAS_REG) begin
            latch_q <= RST_VAL;
        end else if (en) begin
            unique case (MODE)
                WR_FIRST: latch_q <= new_w;
                RD_FIRST: latch_q <= old_w;
                default:  if (!wr) latch_q <= old_w;
            endcase
        end
    end

    if (PRIM_REG) begin : g_prim
        logic [W-1:0] prim_q;
        always_ff @(posedge clk) begin
            if (rst && !CORE_REG) begin
                prim_q <= RST_VAL;
            end else if (CORE_REG ? en : last_ce) begin
                prim_q <= latch_q;
            end
        end
        assign prim_out = prim_q;
    end else begin : g_no_prim
        assign prim_out = latch_q;
    end

    if (CORE_REG) begin : g_core
        logic [W-1:0] core_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                core_q <= RST_VAL;
            end else if (last_ce) begin
                core_q <= prim_out;
            end
        end
        assign core_out = core_q;
    end else begin : g_no_core
        assign core_out = prim_out;
    end

    assign dout = core_out;

endmodule

// File: rtl/dpram_cfg.sv
module dpram_cfg
    import dpram_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 16,
    parameter int          BYTE_W      = 8,
    parameter bit          USE_BYTE_WE = 1'b1,
    parameter wmode_e      MODE_A      = WR_FIRST,
    parameter bit          PRIM_REG_A  = 1'b1,
    parameter bit          CORE_REG_A  = 1'b1,
    parameter bit          USE_RCE_A   = 1'b1,
    parameter logic [DATA_W-1:0] RST_VAL_A = 16'hA5A5,
    parameter wmode_e      MODE_B      = RD_FIRST,
    parameter bit          PRIM_REG_B  = 1'b0,
    parameter bit          CORE_REG_B  = 1'b1,
    parameter bit          USE_RCE_B   = 1'b1,
    parameter logic [DATA_W-1:0] RST_VAL_B = 16'h3C3C
) (
    input  logic clk,
    input  logic rst_a,
    input  logic en_a,
    input  logic regce_a,
    input  logic [lane_count(DATA_W, BYTE_W, USE_BYTE_WE)-1:0] we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    input  logic rst_b,
    input  logic en_b,
    input  logic regce_b,
    input  logic [lane_count(DATA_W, BYTE_W, USE_BYTE_WE)-1:0] we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_b
);
    localparam int LANES  = lane_count(DATA_W, BYTE_W, USE_BYTE_WE);
    localparam int LANE_W = lane_width(DATA_W, BYTE_W, USE_BYTE_WE);

    logic [DATA_W-1:0] old_a, new_a, old_b, new_b;

    dpram_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)
    ) u_array (
        .clk(clk),
        .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
        .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b),
        .old_a(old_a), .new_a(new_a), .old_b(old_b), .new_b(new_b)
    );

    dpram_port_out #(
        .W(DATA_W), .MODE(MODE_A), .PRIM_REG(PRIM_REG_A), .CORE_REG(CORE_REG_A),
        .USE_RCE(USE_RCE_A), .RST_VAL(RST_VAL_A)
    ) u_out_a (
        .clk(clk), .rst(rst_a), .en(en_a), .regce(regce_a), .wr(|we_a),
        .old_w(old_a), .new_w(new_a), .dout(dout_a)
    );

    dpram_port_out #(
        .W(DATA_W), .MODE(MODE_B), .PRIM_REG(PRIM_REG_B), .CORE_REG(CORE_REG_B),
        .USE_RCE(USE_RCE_B), .RST_VAL(RST_VAL_B)
    ) u_out_b (
        .clk(clk), .rst(rst_b), .en(en_b), .regce(regce_b), .wr(|we_b),
        .old_w(old_b), .new_w(new_b), .dout(dout_b)
    );

endmodule

// File: rtl/dpram_cfg_chk.sv
module dpram_cfg_chk
    import dpram_pkg::*;
#(
    parameter int     DATA_W     = 16,
    parameter int     WE_W       = 2,
    parameter wmode_e MODE_A     = WR_FIRST,
    parameter bit     PRIM_REG_A = 1'b0,
    parameter bit     CORE_REG_A = 1'b0,
    parameter bit     USE_RCE_A  = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL_A = '0,
    parameter wmode_e MODE_B     = WR_FIRST,
    parameter bit     PRIM_REG_B = 1'b0,
    parameter bit     CORE_REG_B = 1'b0,
    parameter bit     USE_RCE_B  = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL_B = '0
) (
    input logic              clk,
    input logic              rst_a,
    input logic              en_a,
    input logic              regce_a,
    input logic [WE_W-1:0]   we_a,
    input logic [DATA_W-1:0] dout_a,
    input logic              rst_b,
    input logic              en_b,
    input logic              regce_b,
    input logic [WE_W-1:0]   we_b,
    input logic [DATA_W-1:0] dout_b
);
    localparam bit RCE_LAST_A = USE_RCE_A && (PRIM_REG_A || CORE_REG_A);
    localparam bit RCE_LAST_B = USE_RCE_B && (PRIM_REG_B || CORE_REG_B);
    localparam bit BARE_NC_A  = (MODE_A == NO_CHG) && !PRIM_REG_A && !CORE_REG_A;
    localparam bit BARE_NC_B  = (MODE_B == NO_CHG) && !PRIM_REG_B && !CORE_REG_B;

    // R9
    regce_hold_a_chk: assert property (@(posedge clk) disable iff (rst_a)
        (RCE_LAST_A && !regce_a) |=> $stable(dout_a));
    // R9
    regce_hold_b_chk: assert property (@(posedge clk) disable iff (rst_b)
        (RCE_LAST_B && !regce_b) |=> $stable(dout_b));
    // R8
    en_hold_a_chk: assert property (@(posedge clk) disable iff (rst_a)
        (!RCE_LAST_A && !en_a) |=> $stable(dout_a));
    // R8
    en_hold_b_chk: assert property (@(posedge clk) disable iff (rst_b)
        (!RCE_LAST_B && !en_b) |=> $stable(dout_b));
    // R10
    rst_load_a_chk: assert property (@(posedge clk) disable iff (rst_a)
        $fell(rst_a) |-> (dout_a == RST_VAL_A));
    // R10
    rst_load_b_chk: assert property (@(posedge clk) disable iff (rst_b)
        $fell(rst_b) |-> (dout_b == RST_VAL_B));
    // R5
    nochg_hold_a_chk: assert property (@(posedge clk) disable iff (rst_a)
        (BARE_NC_A && en_a && (|we_a)) |=> $stable(dout_a));
    // R5
    nochg_hold_b_chk: assert property (@(posedge clk) disable iff (rst_b)
        (BARE_NC_B && en_b && (|we_b)) |=> $stable(dout_b));

endmodule

bind dpram_cfg dpram_cfg_chk #(
    .DATA_W(DATA_W), .WE_W(LANES),
    .MODE_A(MODE_A), .PRIM_REG_A(PRIM_REG_A), .CORE_REG_A(CORE_REG_A),
    .USE_RCE_A(USE_RCE_A), .RST_VAL_A(RST_VAL_A),
    .MODE_B(MODE_B), .PRIM_REG_B(PRIM_REG_B), .CORE_REG_B(CORE_REG_B),
    .USE_RCE_B(USE_RCE_B), .RST_VAL_B(RST_VAL_B)
) u_chk (
    .clk(clk),
    .rst_a(rst_a), .en_a(en_a), .regce_a(regce_a), .we_a(we_a), .dout_a(dout_a),
    .rst_b(rst_b), .en_b(en_b), .regce_b(regce_b), .we_b(we_b), .dout_b(dout_b)
);

// File: tb/dpram_cfg_test.sv
module dpram_cfg_test;
    import dpram_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_a, rst_b, en_a, en_b, rce_a, rce_b;
    logic [1:0]  we_a, we_b;
    logic [3:0]  addr_a, addr_b;
    logic [15:0] din_a, din_b;
    logic [15:0] d0a, d0b, d1a, d1b;

    // Instance 1: A write-first, latency 3 with regce; B read-first, latency 2 with regce.
    dpram_cfg uut (
        .clk(clk),
        .rst_a(rst_a), .en_a(en_a), .regce_a(rce_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(d0a),
        .rst_b(rst_b), .en_b(en_b), .regce_b(rce_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(d0b)
    );

    // Instance 2: A no-change, no registers; B write-first, array register only.
    dpram_cfg #(
        .MODE_A(NO_CHG), .PRIM_REG_A(1'b0), .CORE_REG_A(1'b0), .USE_RCE_A(1'b1),
        .RST_VAL_A(16'h0F0F),
        .MODE_B(WR_FIRST), .PRIM_REG_B(1'b1), .CORE_REG_B(1'b0), .USE_RCE_B(1'b0),
        .RST_VAL_B(16'hF00F)
    ) uut_alt (
        .clk(clk),
        .rst_a(rst_a), .en_a(en_a), .regce_a(rce_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(d1a),
        .rst_b(rst_b), .en_b(en_b), .regce_b(rce_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(d1b)
    );

    typedef struct {
        int          mode;
        bit          prim;
        bit          core;
        bit          rce;
        logic [15:0] rstv;
    } cfg_t;

    typedef struct {
        logic [15:0] l;
        logic [15:0] s1;
        logic [15:0] s2;
        bit          lv;
        bit          s1v;
        bit          s2v;
    } pst_t;

    cfg_t        cfg [4];
    pst_t        st  [4];
    logic [15:0] mm  [16];
    bit          km  [16];
    int          ntests = 0;
    int          nfail  = 0;
    string       tag    = "";

    function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] d, logic [1:0] w);
        logic [15:0] r = o;
        for (int k = 0; k < 2; k++) if (w[k]) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    // Reference model of one port: latency 1 + prim + core, modes, enables, reset.
    function automatic pst_t adv(pst_t s, cfg_t c, bit rst, bit en, bit rce, bit wr,
                                 logic [15:0] ow, logic [15:0] nw, bit vin);
        pst_t n   = s;
        bit   has = c.prim || c.core;
        bit   lce = (c.rce && has) ? rce : en;
        if (rst && !has) begin
            n.l = c.rstv; n.lv = 1'b1;
        end else if (en) begin
            if (c.mode == 0) begin n.l = nw; n.lv = vin; end
            else if (c.mode == 1) begin n.l = ow; n.lv = vin; end
            else if (!wr) begin n.l = ow; n.lv = vin; end
        end
        if (c.prim) begin
            if (rst && !c.core) begin n.s1 = c.rstv; n.s1v = 1'b1; end
            else if (c.core ? en : lce) begin n.s1 = s.l; n.s1v = s.lv; end
        end
        if (c.core) begin
            if (rst) begin n.s2 = c.rstv; n.s2v = 1'b1; end
            else if (lce) begin
                n.s2  = c.prim ? s.s1  : s.l;
                n.s2v = c.prim ? s.s1v : s.lv;
            end
        end
        return n;
    endfunction

    task automatic chk(int i, logic [15:0] act);
        logic [15:0] e = cfg[i].core ? st[i].s2  : (cfg[i].prim ? st[i].s1  : st[i].l);
        bit          v = cfg[i].core ? st[i].s2v : (cfg[i].prim ? st[i].s1v : st[i].lv);
        if (v) begin
            ntests++;
            if (act !== e) begin
                nfail++;
                $display("FAIL %s port slot %0d: actual %h expected %h", tag, i, act, e);
            end
        end
    endtask

    task automatic step();
        logic [15:0] oa = mm[addr_a];
        logic [15:0] ob = mm[addr_b];
        bit wa = en_a && (we_a != 2'b00);
        bit wb = en_b && (we_b != 2'b00);
        bit va = km[addr_a] && !(wb && addr_b == addr_a);
        bit vb = km[addr_b] && !(wa && addr_a == addr_b);
        logic [15:0] na = merge(oa, din_a, en_a ? we_a : 2'b00);
        logic [15:0] nb = merge(ob, din_b, en_b ? we_b : 2'b00);
        for (int i = 0; i < 4; i++) begin
            if (i % 2 == 0) st[i] = adv(st[i], cfg[i], rst_a, en_a, rce_a, wa, oa, na, va);
            else            st[i] = adv(st[i], cfg[i], rst_b, en_b, rce_b, wb, ob, nb, vb);
        end
        // B first, then A: A owns the lanes it writes (R7).
        if (en_b) begin
            mm[addr_b] = merge(mm[addr_b], din_b, we_b);
            if (we_b == 2'b11) km[addr_b] = 1'b1;
        end
        if (en_a) begin
            mm[addr_a] = merge(mm[addr_a], din_a, we_a);
            if (we_a == 2'b11) km[addr_a] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(0, d0a); chk(1, d0b); chk(2, d1a); chk(3, d1b);
    endtask

    task automatic idle();
        rst_a = 0; rst_b = 0; en_a = 0; en_b = 0; rce_a = 0; rce_b = 0;
        we_a = 0; we_b = 0; addr_a = 0; addr_b = 0; din_a = 0; din_b = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        cfg[0] = '{0, 1'b1, 1'b1, 1'b1, 16'hA5A5};
        cfg[1] = '{1, 1'b0, 1'b1, 1'b1, 16'h3C3C};
        cfg[2] = '{2, 1'b0, 1'b0, 1'b1, 16'h0F0F};
        cfg[3] = '{0, 1'b1, 1'b0, 1'b0, 16'hF00F};
        for (int i = 0; i < 4; i++) st[i] = '{16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0};
        for (int a = 0; a < 16; a++) begin mm[a] = 16'h0; km[a] = 1'b0; end
        void'($urandom(32'd917));
        idle();
        rst_a = 1; rst_b = 1;
        @(negedge clk);

        // R10: reset value at every last stage (explicit check).
        tag = "R10 reset";
        repeat (3) step();
        begin
            logic [15:0] got [4];
            got[0] = d0a; got[1] = d0b; got[2] = d1a; got[3] = d1b;
            for (int i = 0; i < 4; i++) begin
                ntests++;
                if (got[i] !== cfg[i].rstv) begin
                    nfail++;
                    $display("FAIL R10 reset value slot %0d: actual %h expected %h",
                             i, got[i], cfg[i].rstv);
                end
            end
        end
        idle();

        // R1 R6: fill every word through port A with both lanes enabled.
        tag = "R1 R6 fill";
        for (int a = 0; a < 16; a++) begin
            en_a = 1; rce_a = 1; we_a = 2'b11; addr_a = 4'(a);
            din_a = 16'(a * 16'h1357) ^ 16'h5AA5;
            step();
        end
        idle();

        // R1 R2 R11: read back through both ports, then flush the pipelines.
        tag = "R1 R2 R11 readback";
        for (int a = 0; a < 20; a++) begin
            en_a = 1; en_b = 1; rce_a = 1; rce_b = 1;
            addr_a = 4'(15 - (a % 16)); addr_b = 4'(a % 16);
            step();
        end

        // R3 R4 R5 R6: writes with lane patterns on disjoint halves of the array.
        tag = "R3 R4 R5 R6 write modes";
        for (int k = 0; k < 48; k++) begin
            en_a = 1; en_b = 1; rce_a = 1; rce_b = 1;
            we_a = 2'($urandom); we_b = 2'($urandom);
            addr_a = 4'(k % 8); addr_b = 4'(8 + (k % 8));
            din_a = 16'($urandom); din_b = 16'($urandom);
            step();
        end

        // R7: same address written by both ports, then read back.
        tag = "R7 same-address priority";
        for (int k = 0; k < 8; k++) begin
            en_a = 1; en_b = 1; rce_a = 1; rce_b = 1;
            addr_a = 4'(k); addr_b = 4'(k);
            we_a = 2'(k % 4); we_b = 2'b11;
            din_a = 16'hC000 + 16'(k); din_b = 16'h00D0 + 16'(k * 256);
            step();
        end
        we_a = 0; we_b = 0;
        for (int k = 0; k < 12; k++) begin
            addr_a = 4'(k % 8); addr_b = 4'((k + 3) % 8);
            step();
        end

        // R8 R9 R10 R11: random enables, register enables, resets and hot addresses.
        tag = "R8 R9 R10 R11 random";
        for (int k = 0; k < 3000; k++) begin
            rst_a = ($urandom % 32) == 0; rst_b = ($urandom % 32) == 0;
            en_a = ($urandom % 4) != 0;   en_b = ($urandom % 4) != 0;
            rce_a = ($urandom % 3) != 0;  rce_b = ($urandom % 3) != 0;
            we_a = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
            we_b = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
            addr_a = (k % 2 == 0) ? 4'($urandom % 4) : 4'($urandom);
            addr_b = (k % 2 == 0) ? 4'($urandom % 4) : 4'($urandom);
            din_a = 16'($urandom); din_b = 16'($urandom);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule